// File: doc/BRIEF.md
# Banked Reset Line Controller

This block holds a set of active-high reset outputs that software controls through a small 32-bit register bus. The outputs are grouped into banks of 32. A line with global number `id` belongs to bank `id >> 5` at bit `id & 31`, and it appears on `rst_lines[id]`. Each bank gives software three views of its lines. One word asserts every line whose mask bit is written as 1. A second word releases every line whose mask bit is written as 1. A third word reads back which lines are held in reset. Because the assert and release actions sit at separate addresses, two agents can drive different lines of the same bank without a read-modify-write race.

Banks sit at a stride of 24 bytes. Each bank owns three live words and three reserved words. Every clear write to a bank starts that bank's settle timer, which is sized from a clock frequency and a settle time in nanoseconds (14 µs by default). The bank's `bank_settled` flag drops at that write and returns only when the timer runs out. Logic downstream can treat a high flag as meaning that every block released in that bank has had its worst-case start-up time.

Top module: `banked_reset_ctrl`

## Requirements
- R1: After reset every line in `rst_lines` is 1, every bit of `bank_settled` is 1, and `bus_rdata` is 0.
- R2: Bank `n` covers byte addresses `n*24` to `n*24+23`. Within the bank, the assert word is at offset 0x00, the release word at 0x04 and the status word at 0x08. Bit `i` of bank `n` drives `rst_lines[n*32+i]`.
- R3: A write to an assert word sets to 1 each line of that bank whose data bit is 1. Lines whose data bit is 0 keep their value.
- R4: A write to a release word clears to 0 each line of that bank whose data bit is 1. Lines whose data bit is 0 keep their value.
- R5: A read of a status word returns the 32 lines of that bank, with 1 meaning held in reset. `bus_rdata` carries the result in the cycle after the read is accepted, and it is 0 in any cycle after a cycle with no read.
- R6: A read of an assert word, a release word, a reserved word (offsets 0x0C, 0x10, 0x14), a non-word-aligned address or an address beyond the last bank returns 0.
- R7: A write to a status word, a reserved word, a non-word-aligned address or an address beyond the last bank changes no line.
- R8: A write changes `rst_lines` and the status value at the clock edge that accepts it. Before that edge the outputs hold their old value.
- R9: A release write to bank `n` clears `bank_settled[n]` from the next cycle. The flag rises again exactly SETTLE_CYCLES cycles after the accepting edge. A further release write during the wait restarts the count. Other banks' flags are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write mask |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered |
| rst_lines | output | NUM_BANKS*32 | Reset outputs, 1 = held in reset |
| bank_settled | output | NUM_BANKS | Per-bank flag: no release settle in progress |

## Verification
On every cycle the assertions check the following. A line can rise only on an assert write to its bank and fall only on a release write to its bank. Lines stay put when the bank sees no write. At most one bank decodes any access. Read data is zero after an idle cycle or after a non-status read. A release write always drops the settled flag, and the flag rises only once the counter is empty. Only the bench scenarios can show the other properties: the exact 24-byte stride across all banks, that every single bit of each mask reaches the right output, that reserved and out-of-range writes leave lines unchanged, and the exact cycle on which the settled flag returns, including a restart in the middle of a count.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
    localparam int unsigned LINES_PER_BANK = 32;
    localparam int unsigned BANK_BYTES     = 24;
    localparam int unsigned OFF_ASSERT     = 0;
    localparam int unsigned OFF_RELEASE    = 4;
    localparam int unsigned OFF_STATUS     = 8;

    typedef logic [LINES_PER_BANK-1:0] line_word_t;
endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode
    import rstctl_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    output logic [NUM_BANKS-1:0] assert_hit,
    output logic [NUM_BANKS-1:0] release_hit,
    output logic [NUM_BANKS-1:0] status_hit
);
    logic [31:0] addr_w;
    logic [31:0] off_w;

    always_comb begin
        addr_w      = 32'(addr);
        off_w       = '0;
        assert_hit  = '0;
        release_hit = '0;
        status_hit  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_w >= 32'(b * BANK_BYTES) && addr_w < 32'((b + 1) * BANK_BYTES)) begin
                off_w          = addr_w - 32'(b * BANK_BYTES);
                assert_hit[b]  = wr_en && (off_w == 32'(OFF_ASSERT));
                release_hit[b] = wr_en && (off_w == 32'(OFF_RELEASE));
                status_hit[b]  = rd_en && (off_w == 32'(OFF_STATUS));
            end
        end
    end
endmodule

// File: rtl/rstctl_bank.sv
module rstctl_bank
    import rstctl_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 2800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       assert_wr,
    input  logic       release_wr,
    input  line_word_t mask,
    output line_word_t lines,
    output logic       settled
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES) + 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        line_word_t       lines;
        logic [CNT_W-1:0] cnt;
        logic             settled;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (assert_wr)  st_d.lines = st_q.lines | mask;
        if (release_wr) st_d.lines = st_q.lines & ~mask;
        if (release_wr) begin
            st_d.cnt     = RELOAD;
            st_d.settled = 1'b0;
        end else if (!st_q.settled) begin
            if (st_q.cnt == '0) st_d.settled = 1'b1;
            else                st_d.cnt     = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lines   <= '1;
            st_q.cnt     <= '0;
            st_q.settled <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lines   = st_q.lines;
    assign settled = st_q.settled;

    // R3: a line can rise only on an assert write
    a_r3_rise_needs_assert: assert property (@(posedge clk) disable iff (!rst_n)
        !assert_wr |=> ((lines & ~$past(lines)) == '0));
    // R4: a line can fall only on a release write
    a_r4_fall_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        !release_wr |=> ((~lines & $past(lines)) == '0));
    // R7: no write to this bank, no change
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!assert_wr && !release_wr) |=> $stable(lines));
    // R9: release write drops settled
    a_r9_release_drops: assert property (@(posedge clk) disable iff (!rst_n)
        release_wr |=> !settled);
    // R9: settled returns only after the counter emptied
    a_r9_rise_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> $past(st_q.cnt == '0));
endmodule

// File: rtl/banked_reset_ctrl.sv
module banked_reset_ctrl
    import rstctl_pkg::*;
#(
    parameter int unsigned NUM_BANKS    = 2,
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned CLK_FREQ_MHZ = 200,
    parameter int unsigned SETTLE_NS    = 14000
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic                                bus_wr,
    input  logic [31:0]                         bus_wdata,
    input  logic                                bus_rd,
    output logic [31:0]                         bus_rdata,
    output logic [NUM_BANKS*LINES_PER_BANK-1:0] rst_lines,
    output logic [NUM_BANKS-1:0]                bank_settled
);
    localparam int unsigned SETTLE_RAW    = (SETTLE_NS * CLK_FREQ_MHZ + 999) / 1000;
    localparam int unsigned SETTLE_CYCLES = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

    typedef struct packed {
        logic [31:0] rdata;
    } rd_state_t;

    logic [NUM_BANKS-1:0] assert_hit, release_hit, status_hit;
    line_word_t [NUM_BANKS-1:0] bank_lines;
    rd_state_t rd_d, rd_q;

    rstctl_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_decode (
        .addr        (bus_addr),
        .wr_en       (bus_wr),
        .rd_en       (bus_rd),
        .assert_hit  (assert_hit),
        .release_hit (release_hit),
        .status_hit  (status_hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rstctl_bank #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .assert_wr  (assert_hit[b]),
            .release_wr (release_hit[b]),
            .mask       (bus_wdata),
            .lines      (bank_lines[b]),
            .settled    (bank_settled[b])
        );
    end

    always_comb begin
        rd_d.rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (status_hit[b]) rd_d.rdata = bank_lines[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;
    assign rst_lines = bank_lines;

    // R2: at most one bank decodes an access
    a_r2_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(assert_hit | release_hit | status_hit));
    // R5: no read, zero data next cycle
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));
    // R6: reads that hit no status word return zero
    a_r6_nonstatus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (status_hit == '0)) |=> (bus_rdata == '0));
endmodule

// File: tb/banked_reset_ctrl_test.sv
module banked_reset_ctrl_test;
    localparam int NB      = 3;
    localparam int SETTLE  = 12;
    localparam int CLK_PER = 10;
    localparam int STRIDE  = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [NB*32-1:0] rst_lines;
    logic [NB-1:0] bank_settled;

    int checks = 0;
    int errors = 0;
    logic [NB-1:0][31:0] model;

    always #(CLK_PER/2) clk = ~clk;

    banked_reset_ctrl #(.NUM_BANKS(NB), .ADDR_W(8), .CLK_FREQ_MHZ(1), .SETTLE_NS(SETTLE*1000)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rst_lines(rst_lines), .bank_settled(bank_settled)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected effect of a write, from R2/R3/R4/R7
    function automatic void model_write(input int a, input logic [31:0] d);
        if (a < NB*STRIDE) begin
            if (a % STRIDE == 0) model[a/STRIDE] = model[a/STRIDE] | d;
            if (a % STRIDE == 4) model[a/STRIDE] = model[a/STRIDE] & ~d;
        end
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr = 8'(a); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 8'(a); bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PER * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        model = '1;
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);

        // R1 reset state
        chk("R1 lines", 128'(rst_lines), 128'({NB*32{1'b1}}));
        chk("R1 settled", 128'(bank_settled), 128'({NB{1'b1}}));
        chk("R1 rdata", 128'(bus_rdata), 128'(0));
        for (int b = 0; b < NB; b++) begin
            rd(b*STRIDE+8, r);
            chk("R1 status", 128'(r), 128'(32'hFFFF_FFFF));
        end
        wait_cycles(1);
        chk("R5 rdata idle", 128'(bus_rdata), 128'(0));

        // R8 timing: unchanged before the edge, changed after
        bus_addr = 8'(STRIDE+4); bus_wdata = 32'h0000_00F0; bus_wr = 1'b1;
        #(CLK_PER/2 - 1);
        chk("R8 before edge", 128'(rst_lines), 128'(model));
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        model_write(STRIDE+4, 32'h0000_00F0);
        chk("R8 after edge", 128'(rst_lines), 128'(model));

        // R2 R3 R4 walking bit over every bank
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < 32; i++) begin
                wr(b*STRIDE+4, 32'hFFFF_FFFF);
                wr(b*STRIDE+0, 32'(1) << i);
                chk("R3 R2 walking assert", 128'(rst_lines), 128'(model));
                wr(b*STRIDE+0, 32'hFFFF_FFFF);
                wr(b*STRIDE+4, 32'(1) << i);
                chk("R4 R2 walking release", 128'(rst_lines), 128'(model));
                rd(b*STRIDE+8, r);
                chk("R5 status", 128'(r), 128'(model[b]));
            end
        end

        // R3 R4 multi-bit masks keep unselected bits
        for (int b = 0; b < NB; b++) begin
            wr(b*STRIDE+4, 32'hA5A5_0F0F ^ 32'(b*32'h0101_0101));
            chk("R4 mask", 128'(rst_lines), 128'(model));
            wr(b*STRIDE+0, 32'h0300_C00C << b);
            chk("R3 mask", 128'(rst_lines), 128'(model));
            rd(b*STRIDE+8, r);
            chk("R5 status mask", 128'(r), 128'(model[b]));
        end

        // R6 reads of non-status words return zero
        for (int b = 0; b < NB; b++) begin
            for (int o = 0; o < STRIDE; o += 4) begin
                if (o != 8) begin
                    rd(b*STRIDE+o, r);
                    chk("R6 non-status read", 128'(r), 128'(0));
                end
            end
            rd(b*STRIDE+9, r);
            chk("R6 unaligned read", 128'(r), 128'(0));
        end
        rd(NB*STRIDE+8, r);
        chk("R6 beyond read", 128'(r), 128'(0));

        // R7 writes that must not touch lines
        wr(STRIDE+4, 32'hFFFF_FFFF);
        wr(STRIDE+0, 32'h5555_0000);
        for (int b = 0; b < NB; b++) begin
            for (int o = 8; o < STRIDE; o += 4) begin
                wr(b*STRIDE+o, 32'hFFFF_FFFF);
                chk("R7 status/reserved write", 128'(rst_lines), 128'(model));
            end
            wr(b*STRIDE+1, 32'hFFFF_FFFF);
            wr(b*STRIDE+5, 32'hFFFF_FFFF);
            chk("R7 unaligned write", 128'(rst_lines), 128'(model));
        end
        wr(NB*STRIDE, 32'hFFFF_FFFF);
        wr(NB*STRIDE+4, 32'hFFFF_FFFF);
        wr(255, 32'hFFFF_FFFF);
        chk("R7 beyond write", 128'(rst_lines), 128'(model));

        // R9 settle timing on bank 1
        wait_cycles(SETTLE + 2);
        chk("R9 all settled", 128'(bank_settled), 128'({NB{1'b1}}));
        wr(STRIDE+0, 32'h0000_0001);
        chk("R9 assert keeps settled", 128'(bank_settled), 128'({NB{1'b1}}));
        wr(STRIDE+4, 32'h0000_0001);
        for (int k = 0; k < SETTLE; k++) begin
            chk("R9 low during count", 128'(bank_settled[1]), 128'(0));
            chk("R9 other banks", 128'({bank_settled[2], bank_settled[0]}), 128'(2'b11));
            @(negedge clk);
        end
        chk("R9 rise at count", 128'(bank_settled[1]), 128'(1));
        // restart in the middle
        wr(STRIDE+4, 32'h0);
        wait_cycles(SETTLE/2 - 1);
        wr(STRIDE+4, 32'h0);
        for (int k = 0; k < SETTLE; k++) begin
            chk("R9 restart low", 128'(bank_settled[1]), 128'(0));
            @(negedge clk);
        end
        chk("R9 restart rise", 128'(bank_settled[1]), 128'(1));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule